// File: doc/BRIEF.md
# Control Register Port with Serial and Parallel Host Access

This block holds the control settings of a three-colour image front end: a 7-bit configuration word, an 8-bit offset code for each colour channel and a 5-bit gain code for each colour channel. A host writes these settings in one of two ways. The first is a 3-wire serial link made of a data line, a shift clock and a write strobe. The second is a parallel bus made of an 8-bit data field and a 3-bit address field. The parallel bus shares its pins with the 12-bit converter result, and only the parallel side can read the settings back.

Two mode inputs decide who drives the shared pins. `conv_off` switches the converter result off the pins, and `port_par` selects the parallel port. One of the four combinations is prohibited. While it is present the block raises `mode_err`, drives no pin and accepts no write. Every control pin is resynchronised into `clk` through a two-stage synchroniser. The pin pad itself is modelled as a per-bit enable vector, `pin_oe`, and a value vector, `pin_out`.

Two state machines do the work. The pin-ownership machine has the states BUS_QUIET (the reset state), BUS_CONV, BUS_FAULT, BUS_PAR_IDLE and BUS_PAR_READ. On every clock it moves to the state selected by the synchronised mode pins and read strobe: {conv_off,port_par} = 00 gives BUS_CONV, 01 gives BUS_FAULT and 10 gives BUS_QUIET. For 11 it gives BUS_PAR_READ while the read strobe is high and BUS_PAR_IDLE otherwise.

The serial machine has the states SER_IDLE, SER_SHIFT, SER_OVER and SER_STROBE, with these transitions:
- SER_IDLE→SER_SHIFT on the first shift-clock rise.
- SER_SHIFT→SER_OVER on a twelfth rise.
- SER_IDLE, SER_SHIFT or SER_OVER→SER_STROBE on a write-strobe rise.
- SER_STROBE→SER_IDLE on a write-strobe fall.
- Any state→SER_IDLE whenever the serial port is inactive.

Top module: `ctrl_reg_port`

## Requirements
- R1: After reset the configuration word is 0 (three-channel correlated-sampling mode, 1 V internal reference, red-first order), all three gain codes are 0, all three offset codes are 0xC0, `mode_err` is low and `pin_oe` is 0.
- R2: Address map: 0 is the 7-bit configuration word, 1/2/3 are the red/green/blue offset codes, and 4/5/6 are the red/green/blue gain codes. A narrower register keeps only the low bits of the written byte.
- R3: A serial frame is 11 bits shifted most significant first on rising shift-clock edges taken while the strobe is low: address bits 2..0, then data bits 7..0. A rise of the write strobe commits the frame to the addressed register.
- R4: A serial frame with fewer or more than 11 shift-clock rises before the strobe rises is discarded. The bit count clears when the strobe falls, so the next frame is accepted normally.
- R5: In parallel mode a write-strobe rise stores `pin_in[7:0]` into the register addressed by `pin_in[10:8]`. While the read strobe is high, only `pin_oe[7:0]` is set, and `pin_out[7:0]` carries the addressed register, zero-extended.
- R6: Writes to address 7 change no register. Reads of address 7 return 0.
- R7: With {conv_off,port_par}=00 all 12 pins are driven and `pin_out` equals `conv_data`. The serial port is active.
- R8: With {conv_off,port_par}=10 no pin is driven and the serial port is active.
- R9: With {conv_off,port_par}=01 `mode_err` is high, no pin is driven, and neither serial nor parallel writes take effect.
- R10: Serial clock activity in parallel mode does not carry over into serial mode. A strobe in serial mode without a complete frame leaves all registers unchanged, whatever the bus pins hold.
- R11: A register write becomes visible after the third rising `clk` edge following the strobe pin's rise, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data line |
| wr_stb | input | 1 | Write strobe shared by both ports |
| rd_stb | input | 1 | Parallel read strobe |
| conv_off | input | 1 | High removes converter data from the pins |
| port_par | input | 1 | High selects the parallel port |
| conv_data | input | 12 | Converter result to place on the pins |
| pin_in | input | 11 | Sensed level of shared pins 10..0 (address 10..8, data 7..0) |
| pin_out | output | 12 | Value driven on the shared pins |
| pin_oe | output | 12 | Per-pin drive enable |
| mode_err | output | 1 | Prohibited mode present |
| cfg | output | 7 | Configuration word |
| off_r | output | 8 | Red offset code |
| off_g | output | 8 | Green offset code |
| off_b | output | 8 | Blue offset code |
| gain_r | output | 5 | Red gain code |
| gain_g | output | 5 | Green gain code |
| gain_b | output | 5 | Blue gain code |

## Verification
Each pin change passes through two synchroniser flops and one state or edge register. A register write, a serial shift and a change of pin ownership therefore all show up after the third rising edge following the pin change. The bench drives every pin at a falling edge and holds it for at least four cycles. It queues the expected values and compares them one nanosecond after a rising edge, so every sample falls inside a settled window. The latency requirement is checked directly: the block must show the old value after two rising edges and the new value after the third.

// File: rtl/cregport_pkg.sv
`timescale 1ns/1ps
package cregport_pkg;
    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 8;
    localparam int CFG_W     = 7;
    localparam int GAIN_W    = 5;
    localparam int NCH       = 3;
    localparam int BUS_W     = 12;
    localparam int FRAME_LEN = ADDR_W + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_LEN + 2);

    localparam int CFG_ADDR  = 0;
    localparam int OFF_BASE  = 1;
    localparam int GAIN_BASE = OFF_BASE + NCH;
    localparam int RSVD_ADDR = GAIN_BASE + NCH;

    localparam logic [DATA_W-1:0] OFFSET_RST = 8'hC0;

    typedef enum logic [1:0] {
        SER_IDLE,
        SER_SHIFT,
        SER_OVER,
        SER_STROBE
    } ser_state_e;

    typedef enum logic [2:0] {
        BUS_QUIET,
        BUS_CONV,
        BUS_FAULT,
        BUS_PAR_IDLE,
        BUS_PAR_READ
    } bus_state_e;
endpackage

// File: rtl/cregport_sync.sv
`timescale 1ns/1ps
module cregport_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic [WIDTH-1:0] r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r <= '0;
                else        r <= d;
            end
            assign q = r;
        end else begin : g_chain
            localparam int TOT = STAGES * WIDTH;
            logic [TOT-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[TOT-WIDTH-1:0], d};
            end
            assign q = chain[TOT-1 -: WIDTH];
        end
    endgenerate
endmodule

// File: rtl/cregport_serial.sv
`timescale 1ns/1ps
module cregport_serial
    import cregport_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 active,
    input  logic                 sclk_rise,
    input  logic                 wr_rise,
    input  logic                 wr_fall,
    input  logic                 wr_lvl,
    input  logic                 sdat,
    output logic                 commit,
    output logic [FRAME_LEN-1:0] frame
);
    ser_state_e        state, nxt;
    logic [CNT_W-1:0]  cnt;
    logic              shift_en;
    logic              cnt_full;

    assign cnt_full = (cnt == CNT_W'(FRAME_LEN));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SER_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (!active) begin
            nxt = SER_IDLE;
        end else begin
            unique case (state)
                SER_IDLE: begin
                    if (wr_rise)                     nxt = SER_STROBE;
                    else if (sclk_rise && !wr_lvl)   nxt = SER_SHIFT;
                end
                SER_SHIFT: begin
                    if (wr_rise)                               nxt = SER_STROBE;
                    else if (sclk_rise && !wr_lvl && cnt_full) nxt = SER_OVER;
                end
                SER_OVER: begin
                    if (wr_rise) nxt = SER_STROBE;
                end
                SER_STROBE: begin
                    if (wr_fall) nxt = SER_IDLE;
                end
                default: nxt = SER_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        commit   = 1'b0;
        shift_en = 1'b0;
        if (active) begin
            unique case (state)
                SER_IDLE:   shift_en = sclk_rise && !wr_lvl && !wr_rise;
                SER_SHIFT: begin
                    shift_en = sclk_rise && !wr_lvl && !wr_rise;
                    commit   = wr_rise && cnt_full;
                end
                SER_OVER:   shift_en = 1'b0;
                SER_STROBE: shift_en = 1'b0;
                default:    shift_en = 1'b0;
            endcase
        end
    end

    // shift register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame <= '0;
            cnt   <= '0;
        end else if (!active) begin
            cnt <= '0;
        end else if (state == SER_STROBE && wr_fall) begin
            cnt <= '0;
        end else if (shift_en) begin
            frame <= {frame[FRAME_LEN-2:0], sdat};
            if (cnt <= CNT_W'(FRAME_LEN)) cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cregport_regfile.sv
`timescale 1ns/1ps
module cregport_regfile
    import cregport_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [DATA_W-1:0]       rdata,
    output logic [CFG_W-1:0]        cfg,
    output logic [NCH*DATA_W-1:0]   off_flat,
    output logic [NCH*GAIN_W-1:0]   gain_flat
);
    logic [CFG_W-1:0]  cfg_q;
    logic [DATA_W-1:0] off_arr  [NCH];
    logic [GAIN_W-1:0] gain_arr [NCH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   cfg_q <= '0;
        else if (we && waddr == ADDR_W'(CFG_ADDR))    cfg_q <= wdata[CFG_W-1:0];
    end
    assign cfg = cfg_q;

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
            logic [DATA_W-1:0] off_q;
            logic [GAIN_W-1:0] gain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    off_q  <= OFFSET_RST;
                    gain_q <= '0;
                end else if (we) begin
                    if (waddr == ADDR_W'(OFF_BASE + ch))  off_q  <= wdata;
                    if (waddr == ADDR_W'(GAIN_BASE + ch)) gain_q <= wdata[GAIN_W-1:0];
                end
            end
            assign off_arr[ch]  = off_q;
            assign gain_arr[ch] = gain_q;
            assign off_flat[ch*DATA_W +: DATA_W]  = off_q;
            assign gain_flat[ch*GAIN_W +: GAIN_W] = gain_q;
        end
    endgenerate

    // readback, zero-extended; reserved address reads zero
    always_comb begin
        rdata = '0;
        if (raddr == ADDR_W'(CFG_ADDR)) rdata = DATA_W'(cfg_q);
        for (int ch = 0; ch < NCH; ch++) begin
            if (raddr == ADDR_W'(OFF_BASE + ch))  rdata = off_arr[ch];
            if (raddr == ADDR_W'(GAIN_BASE + ch)) rdata = DATA_W'(gain_arr[ch]);
        end
    end
endmodule

// File: rtl/cregport_busmode.sv
`timescale 1ns/1ps
module cregport_busmode
    import cregport_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_off,
    input  logic             port_par,
    input  logic             rd_req,
    output logic [BUS_W-1:0] pin_oe,
    output logic             drive_conv,
    output logic             mode_err,
    output logic             ser_active,
    output logic             par_active
);
    bus_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= BUS_QUIET;
        else        state <= nxt;
    end

    always_comb begin
        unique case ({conv_off, port_par})
            2'b00:   nxt = BUS_CONV;
            2'b01:   nxt = BUS_FAULT;
            2'b10:   nxt = BUS_QUIET;
            2'b11:   nxt = rd_req ? BUS_PAR_READ : BUS_PAR_IDLE;
            default: nxt = BUS_QUIET;
        endcase
    end

    always_comb begin
        pin_oe     = '0;
        drive_conv = 1'b0;
        mode_err   = 1'b0;
        ser_active = 1'b0;
        par_active = 1'b0;
        unique case (state)
            BUS_QUIET: ser_active = 1'b1;
            BUS_CONV: begin
                pin_oe     = '1;
                drive_conv = 1'b1;
                ser_active = 1'b1;
            end
            BUS_FAULT:    mode_err = 1'b1;
            BUS_PAR_IDLE: par_active = 1'b1;
            BUS_PAR_READ: begin
                par_active          = 1'b1;
                pin_oe[DATA_W-1:0]  = '1;
            end
            default: pin_oe = '0;
        endcase
    end
endmodule

// File: rtl/ctrl_reg_port.sv
`timescale 1ns/1ps
module ctrl_reg_port
    import cregport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ser_clk,
    input  logic                        ser_dat,
    input  logic                        wr_stb,
    input  logic                        rd_stb,
    input  logic                        conv_off,
    input  logic                        port_par,
    input  logic [BUS_W-1:0]            conv_data,
    input  logic [ADDR_W+DATA_W-1:0]    pin_in,
    output logic [BUS_W-1:0]            pin_out,
    output logic [BUS_W-1:0]            pin_oe,
    output logic                        mode_err,
    output logic [CFG_W-1:0]            cfg,
    output logic [DATA_W-1:0]           off_r,
    output logic [DATA_W-1:0]           off_g,
    output logic [DATA_W-1:0]           off_b,
    output logic [GAIN_W-1:0]           gain_r,
    output logic [GAIN_W-1:0]           gain_g,
    output logic [GAIN_W-1:0]           gain_b
);
    localparam int NSYNC = 6;

    logic [NSYNC-1:0] raw_v, syn_v;
    logic sclk_s, sdat_s, wr_s, rd_s, off_s, par_s;
    logic sclk_prev, wr_prev;
    logic sclk_rise, wr_rise, wr_fall;

    assign raw_v = {ser_clk, ser_dat, wr_stb, rd_stb, conv_off, port_par};

    cregport_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_v),
        .q     (syn_v)
    );

    assign {sclk_s, sdat_s, wr_s, rd_s, off_s, par_s} = syn_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            wr_prev   <= 1'b0;
        end else begin
            sclk_prev <= sclk_s;
            wr_prev   <= wr_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_prev;
    assign wr_rise   = wr_s & ~wr_prev;
    assign wr_fall   = ~wr_s & wr_prev;

    logic drive_conv, ser_active, par_active;

    cregport_busmode u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_off   (off_s),
        .port_par   (par_s),
        .rd_req     (rd_s),
        .pin_oe     (pin_oe),
        .drive_conv (drive_conv),
        .mode_err   (mode_err),
        .ser_active (ser_active),
        .par_active (par_active)
    );

    logic                 ser_commit;
    logic [FRAME_LEN-1:0] ser_frame;

    cregport_serial u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (ser_active),
        .sclk_rise (sclk_rise),
        .wr_rise   (wr_rise),
        .wr_fall   (wr_fall),
        .wr_lvl    (wr_s),
        .sdat      (sdat_s),
        .commit    (ser_commit),
        .frame     (ser_frame)
    );

    logic                par_we;
    logic                reg_we;
    logic [ADDR_W-1:0]   reg_waddr;
    logic [DATA_W-1:0]   reg_wdata;
    logic [DATA_W-1:0]   rdata;
    logic [NCH*DATA_W-1:0] off_flat;
    logic [NCH*GAIN_W-1:0] gain_flat;

    assign par_we = par_active & wr_rise;
    assign reg_we = par_we | ser_commit;

    always_comb begin
        if (par_we) begin
            reg_waddr = pin_in[ADDR_W+DATA_W-1:DATA_W];
            reg_wdata = pin_in[DATA_W-1:0];
        end else begin
            reg_waddr = ser_frame[FRAME_LEN-1:DATA_W];
            reg_wdata = ser_frame[DATA_W-1:0];
        end
    end

    cregport_regfile u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .waddr     (reg_waddr),
        .wdata     (reg_wdata),
        .raddr     (pin_in[ADDR_W+DATA_W-1:DATA_W]),
        .rdata     (rdata),
        .cfg       (cfg),
        .off_flat  (off_flat),
        .gain_flat (gain_flat)
    );

    assign pin_out = drive_conv ? conv_data : BUS_W'(rdata);

    assign off_r  = off_flat[0*DATA_W +: DATA_W];
    assign off_g  = off_flat[1*DATA_W +: DATA_W];
    assign off_b  = off_flat[2*DATA_W +: DATA_W];
    assign gain_r = gain_flat[0*GAIN_W +: GAIN_W];
    assign gain_g = gain_flat[1*GAIN_W +: GAIN_W];
    assign gain_b = gain_flat[2*GAIN_W +: GAIN_W];
endmodule

// File: rtl/cregport_chk.sv
`timescale 1ns/1ps
module cregport_chk
    import cregport_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic [ADDR_W+DATA_W-1:0] pin_in,
    input logic [BUS_W-1:0]         pin_oe,
    input logic [BUS_W-1:0]         pin_out,
    input logic                     mode_err,
    input logic                     reg_we,
    input logic [ADDR_W-1:0]        reg_waddr,
    input logic [CFG_W-1:0]         cfg,
    input logic [DATA_W-1:0]        off_r,
    input logic [DATA_W-1:0]        off_g,
    input logic [DATA_W-1:0]        off_b,
    input logic [GAIN_W-1:0]        gain_r,
    input logic [GAIN_W-1:0]        gain_g,
    input logic [GAIN_W-1:0]        gain_b
);
    localparam logic [BUS_W-1:0] RD_MASK = BUS_W'({DATA_W{1'b1}});

    logic [CFG_W+3*DATA_W+3*GAIN_W-1:0] all_regs;
    logic [ADDR_W-1:0] rd_addr;
    logic              reading;

    assign all_regs = {cfg, off_r, off_g, off_b, gain_r, gain_g, gain_b};
    assign rd_addr  = pin_in[ADDR_W+DATA_W-1:DATA_W];
    assign reading  = (pin_oe == RD_MASK);

    p_fault_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> (pin_oe == '0));

    p_fault_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> !reg_we);

    p_oe_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe == '0) || (pin_oe == '1) || reading);

    p_hold_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> $stable(all_regs));

    p_rsvd_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_waddr == ADDR_W'(RSVD_ADDR)) |=> $stable(all_regs));

    p_rsvd_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reading && rd_addr == ADDR_W'(RSVD_ADDR)) |-> (pin_out[DATA_W-1:0] == '0));

    p_gain_zext_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reading && rd_addr >= ADDR_W'(GAIN_BASE) && rd_addr < ADDR_W'(RSVD_ADDR))
        |-> (pin_out[DATA_W-1:GAIN_W] == '0));
endmodule

bind ctrl_reg_port cregport_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_in    (pin_in),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out),
    .mode_err  (mode_err),
    .reg_we    (reg_we),
    .reg_waddr (reg_waddr),
    .cfg       (cfg),
    .off_r     (off_r),
    .off_g     (off_g),
    .off_b     (off_b),
    .gain_r    (gain_r),
    .gain_g    (gain_g),
    .gain_b    (gain_b)
);

// File: tb/sim_ctrl_reg_port.sv
`timescale 1ns/1ps
module sim_ctrl_reg_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0, ser_dat = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
    logic        conv_off = 1'b1, port_par = 1'b0;
    logic [11:0] conv_data = 12'h000;
    logic [10:0] pin_in = 11'h000;
    logic [11:0] pin_out, pin_oe;
    logic        mode_err;
    logic [6:0]  cfg;
    logic [7:0]  off_r, off_g, off_b;
    logic [4:0]  gain_r, gain_g, gain_b;

    int nchk = 0;
    int nfail = 0;

    always #2.5 clk = ~clk;

    ctrl_reg_port u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .conv_off(conv_off), .port_par(port_par),
        .conv_data(conv_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .mode_err(mode_err), .cfg(cfg), .off_r(off_r), .off_g(off_g), .off_b(off_b),
        .gain_r(gain_r), .gain_g(gain_g), .gain_b(gain_b)
    );

    // observable selectors: 0 cfg, 1-3 offsets RGB, 4-6 gains RGB,
    // 7 driven pin value, 8 pin enables, 9 mode error
    typedef struct {
        string       req;
        int          sel;
        logic [11:0] exp;
    } item_t;

    item_t sbq[$];

    function automatic logic [11:0] observe(int sel);
        case (sel)
            0: return {5'h0, cfg};
            1: return {4'h0, off_r};
            2: return {4'h0, off_g};
            3: return {4'h0, off_b};
            4: return {7'h0, gain_r};
            5: return {7'h0, gain_g};
            6: return {7'h0, gain_b};
            7: return pin_out & pin_oe;
            8: return pin_oe;
            default: return {11'h0, mode_err};
        endcase
    endfunction

    task automatic check_now(string req, int sel, logic [11:0] exp);
        logic [11:0] act;
        act = observe(sel);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s sel=%0d actual=%h expected=%h", req, sel, act, exp);
        end
    endtask

    // monitor: compares queued expectations in a settled window
    item_t it;
    always begin
        @(posedge clk);
        #1;
        while (sbq.size() > 0) begin
            it = sbq.pop_front();
            check_now(it.req, it.sel, it.exp);
        end
    end

    task automatic expect_val(string req, int sel, logic [11:0] exp);
        item_t x;
        x.req = req;
        x.sel = sel;
        x.exp = exp;
        sbq.push_back(x);
    endtask

    task automatic flush();
        while (sbq.size() != 0) @(negedge clk);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(logic off, logic par);
        conv_off = off;
        port_par = par;
        idle(6);
    endtask

    task automatic strobe();
        wr_stb = 1'b1;
        idle(5);
        wr_stb = 1'b0;
        idle(5);
    endtask

    task automatic par_write(logic [2:0] a, logic [7:0] d);
        pin_in = {a, d};
        idle(4);
        strobe();
    endtask

    task automatic ser_frame(logic [2:0] a, logic [7:0] d, int nbits);
        logic [10:0] w;
        w = {a, d};
        for (int i = 0; i < nbits; i++) begin
            ser_dat = (i < 11) ? w[10-i] : 1'b0;
            ser_clk = 1'b0;
            idle(4);
            ser_clk = 1'b1;
            idle(4);
        end
        ser_clk = 1'b0;
        idle(4);
        strobe();
    endtask

    task automatic par_read(string req, logic [2:0] a, logic [7:0] exp);
        pin_in = {a, 8'h00};
        rd_stb = 1'b1;
        idle(6);
        expect_val(req, 8, 12'h0FF);
        expect_val(req, 7, {4'h0, exp});
        flush();
        rd_stb = 1'b0;
        idle(5);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(6);

        // R1 reset state
        expect_val("R1", 0, 12'h000);
        expect_val("R1", 1, 12'h0C0);
        expect_val("R1", 2, 12'h0C0);
        expect_val("R1", 3, 12'h0C0);
        expect_val("R1", 4, 12'h000);
        expect_val("R1", 5, 12'h000);
        expect_val("R1", 6, 12'h000);
        expect_val("R1", 9, 12'h000);
        expect_val("R1", 8, 12'h000);
        flush();

        // R7 converter data on all pins
        conv_data = 12'hA5C;
        set_mode(1'b0, 1'b0);
        expect_val("R7", 8, 12'hFFF);
        expect_val("R7", 7, 12'hA5C);
        flush();
        conv_data = 12'h3C3;
        idle(1);
        expect_val("R7", 7, 12'h3C3);
        flush();
        // R7 serial port active while converter drives
        ser_frame(3'd4, 8'h09, 11);
        expect_val("R7", 4, 12'h009);
        flush();

        // R8 quiet pins, serial writes (R3, R2)
        set_mode(1'b1, 1'b0);
        expect_val("R8", 8, 12'h000);
        expect_val("R8", 9, 12'h000);
        flush();
        ser_frame(3'd1, 8'h5A, 11);
        expect_val("R3", 1, 12'h05A);
        flush();
        ser_frame(3'd0, 8'hFF, 11);
        expect_val("R2", 0, 12'h07F);
        flush();
        ser_frame(3'd6, 8'hFF, 11);
        expect_val("R2", 6, 12'h01F);
        flush();

        // R4 short and long frames discarded, next good frame taken
        ser_frame(3'd2, 8'h11, 10);
        expect_val("R4", 2, 12'h0C0);
        flush();
        ser_frame(3'd2, 8'h22, 12);
        expect_val("R4", 2, 12'h0C0);
        flush();
        ser_frame(3'd2, 8'h33, 11);
        expect_val("R4", 2, 12'h033);
        flush();

        // R6 serial write to reserved address
        ser_frame(3'd7, 8'h11, 11);
        expect_val("R6", 0, 12'h07F);
        expect_val("R6", 1, 12'h05A);
        expect_val("R6", 2, 12'h033);
        expect_val("R6", 3, 12'h0C0);
        expect_val("R6", 4, 12'h009);
        expect_val("R6", 6, 12'h01F);
        flush();

        // R9 prohibited mode
        set_mode(1'b0, 1'b1);
        expect_val("R9", 9, 12'h001);
        expect_val("R9", 8, 12'h000);
        flush();
        par_write(3'd5, 8'h1F);
        expect_val("R9", 5, 12'h000);
        flush();
        ser_frame(3'd3, 8'h44, 11);
        expect_val("R9", 3, 12'h0C0);
        flush();

        // R5 parallel mode
        set_mode(1'b1, 1'b1);
        expect_val("R5", 9, 12'h000);
        expect_val("R5", 8, 12'h000);
        flush();
        par_write(3'd4, 8'h15);
        expect_val("R5", 4, 12'h015);
        flush();
        par_write(3'd3, 8'h81);
        expect_val("R5", 3, 12'h081);
        flush();
        par_write(3'd5, 8'hEA);
        expect_val("R2", 5, 12'h00A);
        flush();
        par_write(3'd7, 8'h99);
        expect_val("R6", 0, 12'h07F);
        expect_val("R6", 3, 12'h081);
        expect_val("R6", 6, 12'h01F);
        flush();
        par_read("R5", 3'd3, 8'h81);
        par_read("R5", 3'd5, 8'h0A);
        par_read("R5", 3'd0, 8'h7F);
        par_read("R6", 3'd7, 8'h00);
        par_read("R5", 3'd2, 8'h33);

        // R11 write latency
        pin_in = {3'd6, 8'h07};
        idle(4);
        wr_stb = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1;
        check_now("R11", 6, 12'h01F);
        @(posedge clk);
        #1;
        check_now("R11", 6, 12'h007);
        @(negedge clk);
        wr_stb = 1'b0;
        idle(5);

        // R10 shift clocks in parallel mode do not carry into serial mode
        for (int i = 0; i < 11; i++) begin
            ser_dat = 1'b0;
            ser_clk = 1'b0;
            idle(4);
            ser_clk = 1'b1;
            idle(4);
        end
        ser_clk = 1'b0;
        idle(4);
        pin_in = {3'd1, 8'h00};
        set_mode(1'b1, 1'b0);
        strobe();
        expect_val("R10", 1, 12'h05A);
        expect_val("R10", 0, 12'h07F);
        flush();

        idle(4);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule